// File: doc/BRIEF.md
# Command and Status Register Bank

This block holds the writable control state of a data-unpacking engine and screens every single-word register write that software issues to it. A write arrives as a valid strobe with a register index and a data word. The decoder sorts each index into one of five classes. It is the command register, the error-mask register, the mark register, a read-only register, or an index with no register behind it.

The command register stores nothing. Each of its four bits triggers an action for the one write that carries it: status-clear, stop request, force-break, or full bank reset. When several bits arrive together they take effect from the weakest to the strongest, so reset overrides all the others. The error-mask register keeps three bits. The mark register keeps sixteen bits, and a write to it also drops the mark flag in the status vector.

The engine raises status bits through sticky event inputs. It reads the status vector, the pending-stop flag, the error mask and the mark value from the outputs. A write that is refused produces a one-cycle error pulse. A second pulse marks the case where the index is not mapped at all. The parameter `ENGINE_ID` selects between the two engine instances, and only instance 1 maps the buffer-address register group.

Top module: `csr_bank`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero: status, pending-stop, error mask, mark, error and unmapped.
- R2: A write to index 1 with data bit 0 set (status-clear) zeroes status bits 5..0. These are stop-stall (bit 0), force-break-stall (bit 1), interrupt-stall (bit 2), interrupt (bit 3), error 0 (bit 4) and error 1 (bit 5). The same action clears pending-stop and leaves the mark flag (status bit 6) unchanged.
- R3: A write to index 1 with data bit 1 set (stop) sets pending-stop and does not change any status bit directly. Stop together with status-clear in the same write leaves pending-stop set.
- R4: A write to index 1 with data bit 2 set (force-break) sets status bit 1. Force-break together with status-clear leaves status bit 1 set and bits 0 and 2..5 cleared.
- R5: A write to index 1 with data bit 3 set (reset) returns every output to its reset value, whatever other command bits or event inputs are present in that cycle.
- R6: A write to index 2 stores data bits 2..0 as the error mask and ignores all higher data bits.
- R7: A write to index 3 stores data bits 15..0 as the mark value and clears status bit 6. This holds even if the mark event is raised in the same cycle.
- R8: A write to a read-only index asserts the error output in the next cycle and changes no stored value. The read-only indices are 0 (status), 4..10 (cycle, mode, num, mask, code, two top pointers) and 11..18 (four row and four column registers).
- R9: Indices 19..23 (base, offset, tops, top, double-buffer) are read-only when `ENGINE_ID` is 1. When `ENGINE_ID` is 0 they are unmapped. Indices 24..31 are always unmapped. A write to an unmapped index asserts both the error and the unmapped outputs for one cycle and changes nothing.
- R10: The error and unmapped outputs are high only in the cycle after a refused write. A cycle without a write, or a write to index 1, 2 or 3, leaves both low.
- R11: A high bit of the event input sets the matching status bit, which then stays set. When a command write arrives in the same cycle, its actions apply after the events, so a status-clear wins over a simultaneous event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write strobe |
| wr_idx_i | input | 5 | Register index of the write |
| wr_data_i | input | 32 | Write data word |
| evt_set_i | input | 7 | Engine events; bit n sets status bit n |
| status_o | output | 7 | Status vector (bit layout as in R2, mark flag at bit 6) |
| pending_stop_o | output | 1 | Stop requested, not yet cleared |
| err_mask_o | output | 3 | Stored error mask |
| mark_o | output | 16 | Stored mark value |
| wr_err_o | output | 1 | One-cycle pulse for a refused write |
| wr_unmapped_o | output | 1 | One-cycle pulse when the refused index is unmapped |

## Verification
The bench builds two copies of the bank side by side, one with `ENGINE_ID` set to 1 and one with 0, and sends the same write stream to both. This brings the index group 19..23 into reach from both sides: the same write must be refused as read-only in one copy and as unmapped in the other. All other state must stay identical across the two copies. Random command words cover every mix of the four action bits, together with random event inputs in the same cycle.

// File: rtl/csrb_pkg.sv
package csrb_pkg;

    localparam int STS_W = 7;

    // status vector, bit 0 at the bottom
    typedef struct packed {
        logic mark;
        logic err1;
        logic err0;
        logic irq;
        logic irq_stall;
        logic fbrk_stall;
        logic stop_stall;
    } sts_t;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_CMD,
        CLS_EMASK,
        CLS_MARK,
        CLS_RO
    } cls_e;

    localparam int IDX_STATUS = 0;
    localparam int IDX_CMD    = 1;
    localparam int IDX_EMASK  = 2;
    localparam int IDX_MARK   = 3;
    localparam int IDX_RO_LO  = 4;
    localparam int IDX_RO_HI  = 18;
    localparam int IDX_BUF_LO = 19;
    localparam int IDX_BUF_HI = 23;

    // command action bit positions, weakest first
    localparam int CMD_CLR  = 0;
    localparam int CMD_STOP = 1;
    localparam int CMD_BRK  = 2;
    localparam int CMD_RST  = 3;

endpackage

// File: rtl/csrb_decode.sv
module csrb_decode
    import csrb_pkg::*;
#(
    parameter int ENGINE_ID = 1,
    parameter int IDX_W     = 5
) (
    input  logic [IDX_W-1:0] idx_i,
    output cls_e             cls_o
);
    localparam int IDX_N = 1 << IDX_W;

    logic [31:0] idx_w;
    logic        core_ro;
    logic        buf_ro;

    assign idx_w   = 32'(idx_i);
    assign core_ro = (idx_w == IDX_STATUS) ||
                     (idx_w >= IDX_RO_LO && idx_w <= IDX_RO_HI);

    generate
        if (ENGINE_ID == 1 && IDX_N > IDX_BUF_HI) begin : g_buf_group
            assign buf_ro = (idx_w >= IDX_BUF_LO) && (idx_w <= IDX_BUF_HI);
        end else begin : g_no_buf_group
            assign buf_ro = 1'b0;
        end
    endgenerate

    always_comb begin
        if (idx_w == IDX_CMD)        cls_o = CLS_CMD;
        else if (idx_w == IDX_EMASK) cls_o = CLS_EMASK;
        else if (idx_w == IDX_MARK)  cls_o = CLS_MARK;
        else if (core_ro || buf_ro)  cls_o = CLS_RO;
        else                         cls_o = CLS_NONE;
    end

endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csrb_pkg::*;
#(
    parameter int ENGINE_ID = 1,
    parameter int IDX_W     = 5,
    parameter int DATA_W    = 32,
    parameter int EMASK_W   = 3,
    parameter int MARK_W    = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_valid_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [STS_W-1:0]   evt_set_i,
    output logic [STS_W-1:0]   status_o,
    output logic               pending_stop_o,
    output logic [EMASK_W-1:0] err_mask_o,
    output logic [MARK_W-1:0]  mark_o,
    output logic               wr_err_o,
    output logic               wr_unmapped_o
);
    typedef struct packed {
        sts_t               sts;
        logic               pend;
        logic [EMASK_W-1:0] emask;
        logic [MARK_W-1:0]  mark;
        logic               err;
        logic               unm;
    } state_t;

    state_t state_d, state_q;
    cls_e   cls;

    csrb_decode #(
        .ENGINE_ID (ENGINE_ID),
        .IDX_W     (IDX_W)
    ) decode_i (
        .idx_i (wr_idx_i),
        .cls_o (cls)
    );

    always_comb begin
        state_d     = state_q;
        state_d.err = 1'b0;
        state_d.unm = 1'b0;
        state_d.sts = state_q.sts | sts_t'(evt_set_i);

        if (wr_valid_i) begin
            unique case (cls)
                CLS_CMD: begin
                    if (wr_data_i[CMD_CLR]) begin
                        state_d.sts.stop_stall = 1'b0;
                        state_d.sts.fbrk_stall = 1'b0;
                        state_d.sts.irq_stall  = 1'b0;
                        state_d.sts.irq        = 1'b0;
                        state_d.sts.err0       = 1'b0;
                        state_d.sts.err1       = 1'b0;
                        state_d.pend           = 1'b0;
                    end
                    if (wr_data_i[CMD_STOP]) state_d.pend = 1'b1;
                    if (wr_data_i[CMD_BRK])  state_d.sts.fbrk_stall = 1'b1;
                    if (wr_data_i[CMD_RST])  state_d = '0;
                end
                CLS_EMASK: state_d.emask = wr_data_i[EMASK_W-1:0];
                CLS_MARK: begin
                    state_d.mark     = wr_data_i[MARK_W-1:0];
                    state_d.sts.mark = 1'b0;
                end
                CLS_RO: state_d.err = 1'b1;
                default: begin
                    state_d.err = 1'b1;
                    state_d.unm = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign status_o       = state_q.sts;
    assign pending_stop_o = state_q.pend;
    assign err_mask_o     = state_q.emask;
    assign mark_o         = state_q.mark;
    assign wr_err_o       = state_q.err;
    assign wr_unmapped_o  = state_q.unm;

    logic cmd_wr;
    assign cmd_wr = wr_valid_i && (cls == CLS_CMD);

    AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_wr && wr_data_i[CMD_CLR] && !wr_data_i[CMD_RST] && !wr_data_i[CMD_BRK]
        |=> status_o[5:0] == '0 && pending_stop_o == $past(wr_data_i[CMD_STOP])); // R2

    AST_BREAK_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_wr && wr_data_i[CMD_BRK] && !wr_data_i[CMD_RST] |=> status_o[1]); // R4

    AST_RESET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_wr && wr_data_i[CMD_RST]
        |=> status_o == '0 && !pending_stop_o && err_mask_o == '0 && mark_o == '0); // R5

    AST_MARK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_i && cls == CLS_MARK
        |=> !status_o[STS_W-1] && mark_o == $past(wr_data_i[MARK_W-1:0])); // R7

    AST_RO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_i && (cls == CLS_RO || cls == CLS_NONE) && evt_set_i == '0
        |=> wr_err_o && $stable(status_o) && $stable(pending_stop_o)
            && $stable(err_mask_o) && $stable(mark_o)); // R8

    AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_valid_i |=> !wr_err_o && !wr_unmapped_o); // R10

    AST_UNMAP_IMPLIES_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_unmapped_o |-> wr_err_o); // R9

endmodule

// File: tb/csr_bank_tb.sv
module csr_bank_tb_top;
    import csrb_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        v;
    logic [4:0]  idx;
    logic [31:0] data;
    logic [6:0]  evt;

    logic [6:0]  sts1, sts0;
    logic        pend1, pend0, err1, err0, un1, un0;
    logic [2:0]  em1, em0;
    logic [15:0] mk1, mk0;

    csr_bank #(.ENGINE_ID(1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(v), .wr_idx_i(idx),
        .wr_data_i(data), .evt_set_i(evt), .status_o(sts1),
        .pending_stop_o(pend1), .err_mask_o(em1), .mark_o(mk1),
        .wr_err_o(err1), .wr_unmapped_o(un1));

    csr_bank #(.ENGINE_ID(0)) dut0_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(v), .wr_idx_i(idx),
        .wr_data_i(data), .evt_set_i(evt), .status_o(sts0),
        .pending_stop_o(pend0), .err_mask_o(em0), .mark_o(mk0),
        .wr_err_o(err0), .wr_unmapped_o(un0));

    typedef struct packed {
        logic [6:0]  sts;
        logic        pend;
        logic [2:0]  em;
        logic [15:0] mk;
        logic        err;
        logic        un;
    } mdl_t;

    mdl_t m1, m0;
    int   n_chk = 0;
    int   n_bad = 0;

    // expected next state per the requirements
    function automatic mdl_t mstep(mdl_t m, logic wv, logic [4:0] i,
                                   logic [31:0] d, logic [6:0] e, int id);
        mdl_t n = m;
        n.err = 1'b0;
        n.un  = 1'b0;
        n.sts = m.sts | e;
        if (wv) begin
            if (i == 5'd1) begin
                if (d[0]) begin n.sts[5:0] = '0; n.pend = 1'b0; end
                if (d[1]) n.pend = 1'b1;
                if (d[2]) n.sts[1] = 1'b1;
                if (d[3]) n = '0;
            end else if (i == 5'd2) begin
                n.em = d[2:0];
            end else if (i == 5'd3) begin
                n.mk = d[15:0];
                n.sts[6] = 1'b0;
            end else if (i == 5'd0 || (i >= 5'd4 && i <= 5'd18) ||
                         (id == 1 && i >= 5'd19 && i <= 5'd23)) begin
                n.err = 1'b1;
            end else begin
                n.err = 1'b1;
                n.un  = 1'b1;
            end
        end
        return n;
    endfunction

    function automatic string tag_of(logic wv, logic [4:0] i, logic [31:0] d);
        if (!wv)        return "R10";
        if (i == 5'd1)  return d[3] ? "R5" : "R2";
        if (i == 5'd2)  return "R6";
        if (i == 5'd3)  return "R7";
        if (i <= 5'd18) return "R8";
        return "R9";
    endfunction

    task automatic compare(string tag);
        mdl_t g1, g0;
        g1 = '{sts1, pend1, em1, mk1, err1, un1};
        g0 = '{sts0, pend0, em0, mk0, err0, un0};
        n_chk += 2;
        if (g1 !== m1) begin
            n_bad++;
            $display("FAIL %s id1: actual %h expected %h", tag, g1, m1);
        end
        if (g0 !== m0) begin
            n_bad++;
            $display("FAIL %s id0: actual %h expected %h", tag, g0, m0);
        end
    endtask

    // called just after a negedge: drive, let one posedge pass, check
    task automatic apply(logic wv, logic [4:0] i, logic [31:0] d,
                         logic [6:0] e, string tag);
        v = wv; idx = i; data = d; evt = e;
        m1 = mstep(m1, wv, i, d, e, 1);
        m0 = mstep(m0, wv, i, d, e, 0);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; v = 1'b0; idx = '0; data = '0; evt = '0;
        m1 = '0; m0 = '0;
        repeat (3) @(negedge clk);
        compare("R1");                       // R1 during reset
        rst_n = 1'b1;
        apply(1'b0, 5'd0, 32'h0, 7'h0, "R1"); // R1 first cycle after reset

        apply(1'b0, 5'd0, 32'h0, 7'h7F, "R11");            // R11 events stick
        apply(1'b0, 5'd0, 32'h0, 7'h00, "R11");
        apply(1'b1, 5'd1, 32'h1, 7'h3F, "R11");            // R11 clear wins
        apply(1'b1, 5'd1, 32'h2, 7'h00, "R3");             // R3 stop only
        apply(1'b1, 5'd1, 32'h3, 7'h3F, "R3");             // R3 clear+stop
        apply(1'b1, 5'd1, 32'h5, 7'h3F, "R4");             // R4 clear+break
        apply(1'b1, 5'd1, 32'h1, 7'h00, "R2");             // R2 keeps mark
        apply(1'b1, 5'd2, 32'hFFFF_FFFD, 7'h0, "R6");      // R6 mask=5
        apply(1'b1, 5'd3, 32'hABCD_1234, 7'h40, "R7");     // R7 flag cleared
        apply(1'b1, 5'd7, 32'hFFFF_FFFF, 7'h0, "R8");      // R8 read-only
        apply(1'b1, 5'd0, 32'hFFFF_FFFF, 7'h0, "R8");
        apply(1'b1, 5'd20, 32'h1, 7'h0, "R9");             // R9 buffer group
        apply(1'b1, 5'd31, 32'h1, 7'h0, "R9");             // R9 always unmapped
        apply(1'b0, 5'd31, 32'h1, 7'h0, "R10");            // R10 pulse ends
        apply(1'b1, 5'd2, 32'h3, 7'h0, "R10");             // R10 no err on good write
        apply(1'b1, 5'd1, 32'hF, 7'h7F, "R5");             // R5 reset wins

        for (int k = 0; k < 4000; k++) begin
            logic        wv;
            logic [4:0]  i;
            logic [31:0] d;
            logic [6:0]  e;
            wv = ($urandom % 10) < 7;
            i  = ($urandom % 3 == 0) ? 5'(1 + $urandom % 3) : 5'($urandom);
            d  = $urandom;
            if (i == 5'd1 && ($urandom % 4) != 0) d[3] = 1'b0;
            e  = ($urandom % 4 == 0) ? 7'($urandom) : 7'h0;
            apply(wv, i, d, e, tag_of(wv, i, d));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule